// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block is the host side of a Low Pin Count bus, limited to I/O reads and writes. A request port supplies a 16-bit I/O address, a direction, a size code and up to four bytes of write data. The engine then runs the bus phases on LFRAME# and the 4-bit LAD lines, and reports completion with a one-clock done pulse and the gathered read data. Address decode is assumed to be done before a request reaches this engine.

Each bus cycle carries exactly one data byte. A 2-byte or 4-byte request becomes a chain of byte cycles at ascending addresses, with no idle clock between them. A peripheral that never returns a valid SYNC nibble does not stall the engine. The engine aborts that byte cycle, supplies all-ones for it, as an undriven bus held high by pull-ups would, and carries on with the remaining bytes.

Top module: `lpc_io_host`

## Requirements
- R1: Out of reset and whenever `busy` is low, `lframeN` is high, `ladOe` is low (LAD released) and `rspDone` is low.
- R2: A request is accepted on a clock edge where `reqValid` is high and `busy` is low. On the next clock `busy` is high and START is driven for exactly one clock: `lframeN` low with LAD = 0000.
- R3: After START, `lframeN` returns high and the host drives a type nibble (0000 for read, 0010 for write). It then drives the 16-bit address as four nibbles, most significant first.
- R4: Size code 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Byte i is a full bus cycle at address (base + i) mod 65536, in ascending order, and each cycle's START directly follows the previous cycle's last clock.
- R5: On a write, byte i is taken from `reqWdata[8i+7:8i]` and driven right after the address as two nibbles, low nibble first.
- R6: The host releases LAD (`ladOe` low) for two clocks after the address (read) or the write data (write). It releases LAD for two more clocks after the read data (read) or after the ready SYNC (write).
- R7: During SYNC a LAD value of 0000 means ready, and 0101 or 0110 mean wait, which may repeat without limit. On a read, the two clocks after ready carry the data byte, low nibble first.
- R8: After 4 consecutive SYNC clocks with a nibble that is neither ready nor wait, the host aborts by driving `lframeN` low with LAD = 1111 for 4 clocks. That read byte returns FFh, and the remaining bytes of the request still run.
- R9: A wait nibble restarts the count of invalid SYNC clocks, so invalid clocks separated by a wait never abort.
- R10: `rspRdata` holds read byte i at bits [8i+7:8i], and bytes beyond the request size read as zero. For a write request `rspRdata` is zero.
- R11: `rspDone` is high for exactly one clock, on the clock after the last byte cycle ends, with `rspRdata` valid and `busy` still high. `busy` is low on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LPC clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = I/O write, 0 = I/O read |
| reqAddr | input | 16 | Base I/O address |
| reqSize | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| reqWdata | input | 32 | Write bytes, little-endian |
| busy | output | 1 | Request in progress |
| rspDone | output | 1 | One-clock completion pulse |
| rspRdata | output | 32 | Assembled read data |
| lframeN | output | 1 | LFRAME#, active low |
| ladOut | output | 4 | LAD value driven by host |
| ladOe | output | 1 | Host drives LAD when high |
| ladIn | input | 4 | LAD value seen on the bus |

## Verification
A wrong phase counter or state shows up at the ports within one clock. It appears as a missing or doubled address nibble, as LAD driven during turnaround, or as a START that lasts more than one clock. A wrong byte index or address increment appears in the address nibbles of the second byte cycle, or in the position of a returned byte in `rspRdata`, which is visible at the done pulse. A wrong SYNC timeout count appears as an abort one clock early or late. It can also appear as an abort when invalid nibbles are broken up by waits.

// File: rtl/lpc_io_pkg.sv
package lpc_io_pkg;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_CTYPE, PH_ADDR, PH_WDATA, PH_TAR1,
    PH_SYNC, PH_RDATA, PH_TAR2, PH_ABORT, PH_DONE
  } phase_t;

  typedef enum logic [2:0] {
    LAD_ZERO, LAD_CTYPE, LAD_ADDR, LAD_WDATA, LAD_ONES
  } ladSel_t;

  typedef struct packed {
    logic    loadReq;
    logic    nextByte;
    logic    capLo;
    logic    capHi;
    logic    abortByte;
    logic    frameLow;
    logic    ladDrive;
    ladSel_t ladSel;
    logic [3:0] nibIdx;
  } ctrlStrb_t;

  localparam logic [3:0] NIB_READY = 4'h0;
  localparam logic [3:0] NIB_WAITS = 4'h5;
  localparam logic [3:0] NIB_WAITL = 4'h6;
  localparam logic [3:0] NIB_CT_RD = 4'h0;
  localparam logic [3:0] NIB_CT_WR = 4'h2;

endpackage

// File: rtl/lpc_io_ctrl.sv
module lpc_io_ctrl
  import lpc_io_pkg::*;
#(
  parameter int ADDR_NIBS  = 4,
  parameter int SYNC_LIMIT = 4,
  parameter int ABORT_LEN  = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      isWrite,
  input  logic      lastByte,
  input  logic      syncReady,
  input  logic      syncWait,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      rspDone
);

  localparam int CNT_TOP = (ADDR_NIBS > ABORT_LEN) ? ADDR_NIBS : ABORT_LEN;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);
  localparam int TMO_W   = $clog2(SYNC_LIMIT + 1);

  phase_t             phase, phaseNxt;
  logic [CNT_W-1:0]   cnt, cntNxt;
  logic [TMO_W-1:0]   tmo, tmoNxt;
  logic               byteEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      tmo   <= '0;
    end else begin
      phase <= phaseNxt;
      cnt   <= cntNxt;
      tmo   <= tmoNxt;
    end
  end

  always_comb begin
    phaseNxt    = phase;
    cntNxt      = cnt;
    tmoNxt      = tmo;
    strb        = '0;
    strb.ladSel = LAD_ZERO;
    strb.nibIdx = 4'(cnt);
    rspDone     = 1'b0;
    byteEnd     = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          strb.loadReq = 1'b1;
          phaseNxt     = PH_START;
        end
      end
      PH_START: begin
        strb.frameLow = 1'b1;
        strb.ladDrive = 1'b1;
        strb.ladSel   = LAD_ZERO;
        phaseNxt      = PH_CTYPE;
      end
      PH_CTYPE: begin
        strb.ladDrive = 1'b1;
        strb.ladSel   = LAD_CTYPE;
        cntNxt        = '0;
        phaseNxt      = PH_ADDR;
      end
      PH_ADDR: begin
        strb.ladDrive = 1'b1;
        strb.ladSel   = LAD_ADDR;
        if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
          cntNxt   = '0;
          phaseNxt = isWrite ? PH_WDATA : PH_TAR1;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      PH_WDATA: begin
        strb.ladDrive = 1'b1;
        strb.ladSel   = LAD_WDATA;
        if (cnt == CNT_W'(1)) begin
          cntNxt   = '0;
          phaseNxt = PH_TAR1;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      PH_TAR1: begin
        if (cnt == CNT_W'(1)) begin
          cntNxt   = '0;
          tmoNxt   = '0;
          phaseNxt = PH_SYNC;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      PH_SYNC: begin
        if (syncReady) begin
          cntNxt   = '0;
          phaseNxt = isWrite ? PH_TAR2 : PH_RDATA;
        end else if (syncWait) begin
          tmoNxt = '0;
        end else if (tmo == TMO_W'(SYNC_LIMIT - 1)) begin
          cntNxt   = '0;
          phaseNxt = PH_ABORT;
        end else begin
          tmoNxt = tmo + 1'b1;
        end
      end
      PH_RDATA: begin
        strb.capLo = (cnt == '0);
        strb.capHi = (cnt == CNT_W'(1));
        if (cnt == CNT_W'(1)) begin
          cntNxt   = '0;
          phaseNxt = PH_TAR2;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      PH_TAR2: begin
        if (cnt == CNT_W'(1)) byteEnd = 1'b1;
        else cntNxt = cnt + 1'b1;
      end
      PH_ABORT: begin
        strb.frameLow  = 1'b1;
        strb.ladDrive  = 1'b1;
        strb.ladSel    = LAD_ONES;
        strb.abortByte = (cnt == '0);
        if (cnt == CNT_W'(ABORT_LEN - 1)) byteEnd = 1'b1;
        else cntNxt = cnt + 1'b1;
      end
      PH_DONE: begin
        rspDone  = 1'b1;
        phaseNxt = PH_IDLE;
      end
      default: phaseNxt = PH_IDLE;
    endcase
    if (byteEnd) begin
      cntNxt = '0;
      if (lastByte) begin
        phaseNxt = PH_DONE;
      end else begin
        strb.nextByte = 1'b1;
        phaseNxt      = PH_START;
      end
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/lpc_io_dp.sv
module lpc_io_dp
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrb_t              strb,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqSize,
  input  logic [8*MAX_BYTES-1:0] reqWdata,
  input  logic [3:0]             ladIn,
  output logic                   isWrite,
  output logic                   lastByte,
  output logic                   syncReady,
  output logic                   syncWait,
  output logic [8*MAX_BYTES-1:0] rspRdata,
  output logic                   lframeN,
  output logic [3:0]             ladOut,
  output logic                   ladOe
);

  localparam int DATA_W    = 8 * MAX_BYTES;
  localparam int BIDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
  localparam int ADDR_NIBS = ADDR_W / 4;

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdataReg;
  logic [BIDX_W-1:0] byteIdx;
  logic [BIDX_W-1:0] byteLast;
  logic              writeReg;
  logic [7:0]        curWbyte;
  logic [3:0]        addrNib;

  function automatic logic [BIDX_W-1:0] lastFromSize(input logic [1:0] sz);
    int n;
    case (sz)
      2'd0:    n = 1;
      2'd1:    n = 2;
      default: n = 4;
    endcase
    if (n > MAX_BYTES) n = MAX_BYTES;
    return BIDX_W'(n - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      wdataReg <= '0;
      rdataReg <= '0;
      byteIdx  <= '0;
      byteLast <= '0;
      writeReg <= 1'b0;
    end else if (strb.loadReq) begin
      curAddr  <= reqAddr;
      wdataReg <= reqWdata;
      rdataReg <= '0;
      byteIdx  <= '0;
      byteLast <= lastFromSize(reqSize);
      writeReg <= reqWrite;
    end else begin
      if (strb.capLo)
        rdataReg[{byteIdx, 3'b000} +: 4] <= ladIn;
      if (strb.capHi)
        rdataReg[{byteIdx, 3'b100} +: 4] <= ladIn;
      if (strb.abortByte && !writeReg)
        rdataReg[{byteIdx, 3'b000} +: 8] <= 8'hFF;
      if (strb.nextByte) begin
        curAddr <= curAddr + 1'b1;
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  assign curWbyte = wdataReg[{byteIdx, 3'b000} +: 8];
  assign addrNib  = curAddr[(ADDR_NIBS - 1 - int'(strb.nibIdx)) * 4 +: 4];

  always_comb begin
    case (strb.ladSel)
      LAD_CTYPE: ladOut = writeReg ? NIB_CT_WR : NIB_CT_RD;
      LAD_ADDR:  ladOut = addrNib;
      LAD_WDATA: ladOut = strb.nibIdx[0] ? curWbyte[7:4] : curWbyte[3:0];
      LAD_ONES:  ladOut = 4'hF;
      default:   ladOut = 4'h0;
    endcase
  end

  assign ladOe     = strb.ladDrive;
  assign lframeN   = !strb.frameLow;
  assign isWrite   = writeReg;
  assign lastByte  = (byteIdx == byteLast);
  assign syncReady = (ladIn == NIB_READY);
  assign syncWait  = (ladIn == NIB_WAITS) || (ladIn == NIB_WAITL);
  assign rspRdata  = rdataReg;

endmodule

// File: rtl/lpc_io_host.sv
module lpc_io_host
  import lpc_io_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int MAX_BYTES  = 4,
  parameter int SYNC_LIMIT = 4,
  parameter int ABORT_LEN  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic                   reqWrite,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [1:0]             reqSize,
  input  logic [8*MAX_BYTES-1:0] reqWdata,
  output logic                   busy,
  output logic                   rspDone,
  output logic [8*MAX_BYTES-1:0] rspRdata,
  output logic                   lframeN,
  output logic [3:0]             ladOut,
  output logic                   ladOe,
  input  logic [3:0]             ladIn
);

  localparam int ADDR_NIBS = ADDR_W / 4;

  ctrlStrb_t strb;
  logic      isWrite;
  logic      lastByte;
  logic      syncReady;
  logic      syncWait;

  lpc_io_ctrl #(
    .ADDR_NIBS (ADDR_NIBS),
    .SYNC_LIMIT(SYNC_LIMIT),
    .ABORT_LEN (ABORT_LEN)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .isWrite  (isWrite),
    .lastByte (lastByte),
    .syncReady(syncReady),
    .syncWait (syncWait),
    .strb     (strb),
    .busy     (busy),
    .rspDone  (rspDone)
  );

  lpc_io_dp #(
    .ADDR_W   (ADDR_W),
    .MAX_BYTES(MAX_BYTES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWdata (reqWdata),
    .ladIn    (ladIn),
    .isWrite  (isWrite),
    .lastByte (lastByte),
    .syncReady(syncReady),
    .syncWait (syncWait),
    .rspRdata (rspRdata),
    .lframeN  (lframeN),
    .ladOut   (ladOut),
    .ladOe    (ladOe)
  );

endmodule

// File: rtl/lpc_io_host_chk.sv
module lpc_io_host_chk #(
  parameter int ABORT_LEN = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       busy,
  input logic       rspDone,
  input logic       lframeN,
  input logic [3:0] ladOut,
  input logic       ladOe
);

  localparam int RUN_W = $clog2(ABORT_LEN + 2);

  logic [RUN_W-1:0] abtRun;
  logic [RUN_W-1:0] abtRunPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abtRun     <= '0;
      abtRunPrev <= '0;
    end else begin
      abtRunPrev <= abtRun;
      if (!lframeN && ladOe && ladOut == 4'hF) begin
        if (abtRun != RUN_W'(ABORT_LEN + 1)) abtRun <= abtRun + 1'b1;
      end else begin
        abtRun <= '0;
      end
    end
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (lframeN && !ladOe && !rspDone));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> (busy && !lframeN && ladOe && ladOut == 4'h0));

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lframeN && ladOut == 4'h0) |=> lframeN);

  // R8
  frame_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lframeN |-> (ladOe && (ladOut == 4'h0 || ladOut == 4'hF)));

  // R8
  abort_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (abtRun <= RUN_W'(ABORT_LEN)) &&
    ((abtRun == '0 && abtRunPrev != '0) -> (abtRunPrev == RUN_W'(ABORT_LEN))));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> (!rspDone && !busy));

  // R11
  done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> busy);

endmodule

bind lpc_io_host lpc_io_host_chk #(.ABORT_LEN(ABORT_LEN)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .busy    (busy),
  .rspDone (rspDone),
  .lframeN (lframeN),
  .ladOut  (ladOut),
  .ladOe   (ladOe)
);

// File: tb/lpc_io_host_tb_top.sv
`timescale 1ns/1ps
module lpc_io_host_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        busy;
  logic        rspDone;
  logic [31:0] rspRdata;
  logic        lframeN;
  logic [3:0]  ladOut;
  logic        ladOe;
  logic [3:0]  ladIn = 4'hF;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lpc_io_host dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .busy(busy), .rspDone(rspDone), .rspRdata(rspRdata),
    .lframeN(lframeN), .ladOut(ladOut), .ladOe(ladOe), .ladIn(ladIn)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] periphByte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // Per-byte responder modes (2 bits each): 0 ready, 1 two waits then ready,
  // 2 absent, 3 invalid/wait mix then ready
  task automatic doXfer(input bit wr, input logic [15:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [7:0] modes);
    int nb;
    logic [31:0] expRd;
    nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    expRd = '0;
    @(negedge clk);
    chk(!busy, "R1", 32'(busy), 0);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    for (int b = 0; b < nb; b++) begin
      logic [15:0] a;
      logic [7:0] wb;
      logic [1:0] md;
      a  = addr + 16'(b);
      wb = wd[8*b +: 8];
      md = modes[2*b +: 2];
      // START
      chk(!lframeN && ladOe && ladOut == 4'h0, "R2", {lframeN, ladOe, ladOut}, 32'h10);
      @(negedge clk);
      chk(lframeN && ladOe && ladOut == (wr ? 4'h2 : 4'h0), "R3",
          {lframeN, ladOe, ladOut}, {2'b11, (wr ? 4'h2 : 4'h0)});
      for (int n = 0; n < 4; n++) begin
        logic [3:0] en;
        @(negedge clk);
        en = 4'(a >> (12 - 4 * n));
        chk(lframeN && ladOe && ladOut == en, "R4", {ladOe, ladOut}, {1'b1, en});
      end
      if (wr) begin
        @(negedge clk);
        chk(ladOe && ladOut == wb[3:0], "R5", {ladOe, ladOut}, {1'b1, wb[3:0]});
        @(negedge clk);
        chk(ladOe && ladOut == wb[7:4], "R5", {ladOe, ladOut}, {1'b1, wb[7:4]});
      end
      for (int t = 0; t < 2; t++) begin
        @(negedge clk);
        chk(!ladOe && lframeN, "R6", {lframeN, ladOe}, 32'h2);
      end
      @(negedge clk);
      if (md == 2'd2) begin
        for (int k = 0; k < 4; k++) begin
          ladIn = 4'hF;
          @(negedge clk);
        end
        for (int k = 0; k < 4; k++) begin
          chk(!lframeN && ladOe && ladOut == 4'hF, "R8", {lframeN, ladOe, ladOut}, 32'h1F);
          @(negedge clk);
        end
        if (!wr) expRd[8*b +: 8] = 8'hFF;
      end else begin
        if (md == 2'd1) begin
          ladIn = 4'h5; @(negedge clk);
          ladIn = 4'h6; @(negedge clk);
          chk(!ladOe && lframeN, "R7", {lframeN, ladOe}, 32'h2);
        end else if (md == 2'd3) begin
          for (int k = 0; k < 3; k++) begin ladIn = 4'hF; @(negedge clk); end
          ladIn = 4'h5; @(negedge clk);
          for (int k = 0; k < 3; k++) begin ladIn = 4'hA; @(negedge clk); end
          chk(lframeN && !ladOe, "R9", {lframeN, ladOe}, 32'h2);
        end
        ladIn = 4'h0;
        @(negedge clk);
        if (!wr) begin
          logic [7:0] pb;
          pb = periphByte(a);
          chk(!ladOe && lframeN, "R7", {lframeN, ladOe}, 32'h2);
          ladIn = pb[3:0]; @(negedge clk);
          ladIn = pb[7:4]; @(negedge clk);
          expRd[8*b +: 8] = pb;
        end
        chk(!ladOe && lframeN, "R6", {lframeN, ladOe}, 32'h2);
        ladIn = 4'hF;
        @(negedge clk);
        chk(!ladOe && lframeN, "R6", {lframeN, ladOe}, 32'h2);
        @(negedge clk);
      end
      if (b != nb - 1) chk(!rspDone && busy, "R11", {busy, rspDone}, 32'h2);
    end
    chk(rspDone && busy, "R11", {busy, rspDone}, 32'h3);
    chk(rspRdata == expRd, "R10", rspRdata, expRd);
    @(negedge clk);
    chk(!busy && !rspDone && lframeN && !ladOe, "R1",
        {busy, rspDone, lframeN, ladOe}, 32'h2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(lframeN && !ladOe && !busy && !rspDone, "R1",
        {lframeN, ladOe, busy, rspDone}, 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    chk(lframeN && !ladOe && !busy && !rspDone, "R1",
        {lframeN, ladOe, busy, rspDone}, 32'h8);

    for (int sz = 0; sz < 3; sz++) begin
      for (int wr = 0; wr < 2; wr++) begin
        for (int ai = 0; ai < 4; ai++) begin
          logic [15:0] addr;
          logic [7:0]  modes;
          case (ai)
            0: addr = 16'h0000;
            1: addr = 16'h1234;
            2: addr = 16'hFFFE;
            default: addr = 16'hFFFF;
          endcase
          modes = 8'((sz * 24 + wr * 12 + ai * 5) * 29);
          doXfer(wr[0], addr, 2'(sz), {addr, ~addr} ^ 32'h5A3C9618, modes);
        end
      end
    end
    // R4: size code 3 behaves as four bytes
    doXfer(1'b0, 16'h0380, 2'd3, 32'h0, 8'b00_01_11_00);
    // R8: every byte of a read absent
    doXfer(1'b0, 16'h0060, 2'd2, 32'h0, 8'hAA);
    // R8: absent write leaves rspRdata zero
    doXfer(1'b1, 16'h0070, 2'd1, 32'h0000BEEF, 8'b0000_1010);
    // R9: mixed invalid and wait nibbles on every byte
    doXfer(1'b0, 16'h2F00, 2'd2, 32'h0, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule